// File: doc/BRIEF.md
# Programmable Interval Counter Clock

This block is a real-time clock peripheral for a processor's I/O space. It holds a tick counter, an interval compare register and a small status word. An upstream timebase supplies single-cycle tick pulses. While the clock is enabled, each tick advances the counter. The block sets a compare flag when the counter meets the interval. It sets an overflow flag when the counter wraps. While enabled, either flag raises an interrupt request at a priority level that software programs.

Software reaches the block through one access port that carries four operations:

- a control write, which packs several independent set and clear commands into one word;
- a status read;
- an interval write;
- a counter read.

A user-only mode lets the counter measure only the time spent in user mode, as reported by an input from the processor. While the clock is stopped, a single-step command advances the counter by one.

Top module: `ivl_clock`

## Requirements
- R1: A synchronous active-high reset clears the counter, the interval, every status bit and the interrupt request.
- R2: While enabled, a tick pulse adds one to the counter. While disabled, ticks leave the counter unchanged.
- R3: When an increment carries out of the counter's top bit, the counter wraps to zero and the overflow flag (status bit 4) is set.
- R4: After any increment, the compare flag (status bit 3) is set if the new counter value equals the interval register.
- R5: Every control write loads write bits 2:0 into the priority level (status bits 2:0 and the `irq_level` output).
- R6: Control write bits act on the flags and modes as follows:
  - bit 11 sets the compare flag and bit 3 clears it;
  - bit 12 sets the overflow flag and bit 4 clears it;
  - bit 5 enables the clock and bit 6 disables it;
  - bit 7 sets user-only mode and bit 8 clears it.
  - When a set bit and its clear bit arrive together, the clear wins.
  - Enable reads back at status bit 5 and user-only mode at status bit 7.
- R7: Control write bit 9 zeroes the counter and the whole status word before the other bits of the same write are applied. The interval is untouched.
- R8: Control write bit 10 adds one to the counter, with the R3 and R4 checks, only if the clock is disabled at that moment. That moment is after any bit-9 clear and before the enable and disable bits of the same write take effect.
- R9: A control write first drops the interrupt request. It then reasserts the request if the resulting state is enabled with the compare or overflow flag set.
- R10: An interval write (op 2) loads write bits 17:0 into the interval. If the clock is enabled, the compare flag is set when the new interval equals the counter, and the interrupt request is raised whatever the flags.
- R11: In user-only mode, an enabled tick counts only while `user_mode` is high.
- R12: A status read (op 1) returns the status word in bits 17:0, with bit 9 and the unused bits reading zero, and the interval in bits 35:18. A counter read (op 3) returns the counter in bits 17:0 and zero above.
- R13: A control write or interval write (op 0 or op 2) in the same cycle as a tick takes precedence, and that tick is not counted.
- R14: A tick increment that leaves either flag set raises the interrupt request. The request otherwise holds its value until the next control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access strobe, one cycle per operation |
| acc_op | input | 2 | 0 control write, 1 status read, 2 interval write, 3 counter read |
| wr_data | input | 2*CNT_W (36) | Write data for ops 0 and 2 |
| rd_data | output | 2*CNT_W (36) | Read data for ops 1 and 3, combinational, zero otherwise |
| tick | input | 1 | Timebase tick pulse |
| user_mode | input | 1 | High while the processor runs in user mode |
| irq | output | 1 | Interrupt request level |
| irq_level | output | 3 | Programmed priority level of the request |

## Verification
The bench builds the block with a 10-bit counter and the user-only option present. This brings a full wrap of the counter within reach of a continuous tick sweep, checked at regular points and at the wrap itself. It also means every control word bit, including the upper command bits, still fits in the 20-bit write word. The same configuration allows a sweep of all eight priority levels and of combined set/clear, general-clear and single-step control words, whose outcomes are computed from the bit meanings.

// File: rtl/ivl_clock_pkg.sv
package ivl_clock_pkg;

   localparam int LVL_W = 3;

   typedef enum logic [1:0] {
      OP_CTRL = 2'd0,
      OP_STAT = 2'd1,
      OP_IWR  = 2'd2,
      OP_CRD  = 2'd3
   } op_e;

   // control word command bit positions
   localparam int C_FLG_OFF = 3;
   localparam int C_OVF_OFF = 4;
   localparam int C_RUN_ON  = 5;
   localparam int C_RUN_OFF = 6;
   localparam int C_UO_ON   = 7;
   localparam int C_UO_OFF  = 8;
   localparam int C_WIPE    = 9;
   localparam int C_STEP    = 10;
   localparam int C_FLG_ON  = 11;
   localparam int C_OVF_ON  = 12;
   localparam int CMD_W     = 13;

   // status word bit positions
   localparam int S_FLG = 3;
   localparam int S_OVF = 4;
   localparam int S_RUN = 5;
   localparam int S_UO  = 7;
   localparam int S_EXT = 9;
   localparam int STAT_MIN_W = S_EXT + 1;

   typedef struct packed {
      logic [LVL_W-1:0] lvl;
      logic             flg;
      logic             ovf;
      logic             run;
      logic             uo;
   } stat_t;

endpackage

// File: rtl/ivl_clock_step.sv
module ivl_clock_step #(
   parameter int CNT_W = 18
) (
   input  logic [CNT_W-1:0] cnt_in,
   input  logic [CNT_W-1:0] ival,
   input  logic             bump,
   input  logic             flg_in,
   input  logic             ovf_in,
   output logic [CNT_W-1:0] cnt_out,
   output logic             flg_out,
   output logic             ovf_out
);
   logic [CNT_W:0] sum;

   always_comb begin
      sum     = {1'b0, cnt_in} + {{CNT_W{1'b0}}, 1'b1};
      cnt_out = bump ? sum[CNT_W-1:0] : cnt_in;
      ovf_out = ovf_in | (bump & sum[CNT_W]);
      flg_out = flg_in | (bump & (sum[CNT_W-1:0] == ival));
   end
endmodule

// File: rtl/ivl_clock_gate.sv
module ivl_clock_gate #(
   parameter bit USER_GATE_EN = 1'b1
) (
   input  logic tick,
   input  logic run,
   input  logic uo,
   input  logic user_mode,
   output logic cnt_tick
);
   generate
      if (USER_GATE_EN) begin : g_user_gate
         assign cnt_tick = tick & run & (~uo | user_mode);
      end else begin : g_no_gate
         logic unused_gate;
         assign unused_gate = uo ^ user_mode;
         assign cnt_tick    = tick & run;
      end
   endgenerate
endmodule

// File: rtl/ivl_clock_ctrl.sv
module ivl_clock_ctrl
   import ivl_clock_pkg::*;
#(
   parameter int CNT_W        = 18,
   parameter bit USER_GATE_EN = 1'b1
) (
   input  logic [CMD_W-1:0] cmd,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] ival,
   input  stat_t            st,
   output logic [CNT_W-1:0] cnt_n,
   output stat_t            st_n,
   output logic             irq_n
);
   stat_t            st0;
   logic [CNT_W-1:0] cnt0;
   logic [CNT_W-1:0] cnt1;
   logic             flg1;
   logic             ovf1;
   logic             step;

   always_comb begin
      st0     = cmd[C_WIPE] ? '0 : st;
      cnt0    = cmd[C_WIPE] ? '0 : cnt;
      st0.lvl = cmd[LVL_W-1:0];
      step    = cmd[C_STEP] & ~st0.run;
   end

   ivl_clock_step #(.CNT_W(CNT_W)) u_step (
      .cnt_in (cnt0),
      .ival   (ival),
      .bump   (step),
      .flg_in (st0.flg),
      .ovf_in (st0.ovf),
      .cnt_out(cnt1),
      .flg_out(flg1),
      .ovf_out(ovf1)
   );

   always_comb begin
      cnt_n    = cnt1;
      st_n.lvl = st0.lvl;
      st_n.run = (st0.run | cmd[C_RUN_ON]) & ~cmd[C_RUN_OFF];
      st_n.ovf = (ovf1 | cmd[C_OVF_ON]) & ~cmd[C_OVF_OFF];
      st_n.flg = (flg1 | cmd[C_FLG_ON]) & ~cmd[C_FLG_OFF];
      st_n.uo  = USER_GATE_EN ? ((st0.uo | cmd[C_UO_ON]) & ~cmd[C_UO_OFF]) : 1'b0;
      irq_n    = st_n.run & (st_n.flg | st_n.ovf);
   end
endmodule

// File: rtl/ivl_clock.sv
module ivl_clock
   import ivl_clock_pkg::*;
#(
   parameter int CNT_W        = 18,
   parameter bit USER_GATE_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               acc_en,
   input  logic [1:0]         acc_op,
   input  logic [2*CNT_W-1:0] wr_data,
   output logic [2*CNT_W-1:0] rd_data,
   input  logic               tick,
   input  logic               user_mode,
   output logic               irq,
   output logic [LVL_W-1:0]   irq_level
);
   localparam int DW = 2 * CNT_W;

   generate
      if (CNT_W < STAT_MIN_W) begin : g_bad_width
         $error("ivl_clock: CNT_W must be at least %0d", STAT_MIN_W);
      end
      if (DW < CMD_W) begin : g_bad_cmd
         $error("ivl_clock: write word too narrow for control bits");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q, ival_q;
   logic [LVL_W-1:0] lvl_q;
   logic             flg_q, ovf_q, en_q, uo_q, irq_q;

   logic             wr_ctl, wr_ivl, any_wr;
   logic             cnt_tick, tk_bump;
   logic [CNT_W-1:0] tk_cnt;
   logic             tk_flg, tk_ovf;
   stat_t            st_cur, ctl_st;
   logic [CNT_W-1:0] ctl_cnt;
   logic             ctl_irq;
   logic [CNT_W-1:0] stat_vec;

   assign wr_ctl = acc_en && (acc_op == OP_CTRL);
   assign wr_ivl = acc_en && (acc_op == OP_IWR);
   assign any_wr = wr_ctl | wr_ivl;

   assign st_cur = '{lvl: lvl_q, flg: flg_q, ovf: ovf_q, run: en_q, uo: uo_q};

   ivl_clock_gate #(.USER_GATE_EN(USER_GATE_EN)) u_gate (
      .tick     (tick),
      .run      (en_q),
      .uo       (uo_q),
      .user_mode(user_mode),
      .cnt_tick (cnt_tick)
   );

   assign tk_bump = cnt_tick & ~any_wr;

   ivl_clock_step #(.CNT_W(CNT_W)) u_tick_step (
      .cnt_in (cnt_q),
      .ival   (ival_q),
      .bump   (tk_bump),
      .flg_in (flg_q),
      .ovf_in (ovf_q),
      .cnt_out(tk_cnt),
      .flg_out(tk_flg),
      .ovf_out(tk_ovf)
   );

   ivl_clock_ctrl #(.CNT_W(CNT_W), .USER_GATE_EN(USER_GATE_EN)) u_ctrl (
      .cmd  (wr_data[CMD_W-1:0]),
      .cnt  (cnt_q),
      .ival (ival_q),
      .st   (st_cur),
      .cnt_n(ctl_cnt),
      .st_n (ctl_st),
      .irq_n(ctl_irq)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= '0;
         ival_q <= '0;
         lvl_q  <= '0;
         flg_q  <= 1'b0;
         ovf_q  <= 1'b0;
         en_q   <= 1'b0;
         uo_q   <= 1'b0;
         irq_q  <= 1'b0;
      end else if (wr_ctl) begin
         cnt_q <= ctl_cnt;
         lvl_q <= ctl_st.lvl;
         flg_q <= ctl_st.flg;
         ovf_q <= ctl_st.ovf;
         en_q  <= ctl_st.run;
         uo_q  <= ctl_st.uo;
         irq_q <= ctl_irq;
      end else if (wr_ivl) begin
         ival_q <= wr_data[CNT_W-1:0];
         if (en_q) begin
            if (wr_data[CNT_W-1:0] == cnt_q) flg_q <= 1'b1;
            irq_q <= 1'b1;
         end
      end else if (tk_bump) begin
         cnt_q <= tk_cnt;
         flg_q <= tk_flg;
         ovf_q <= tk_ovf;
         if (tk_flg | tk_ovf) irq_q <= 1'b1;
      end
   end

   always_comb begin
      stat_vec              = '0;
      stat_vec[LVL_W-1:0]   = lvl_q;
      stat_vec[S_FLG]       = flg_q;
      stat_vec[S_OVF]       = ovf_q;
      stat_vec[S_RUN]       = en_q;
      stat_vec[S_UO]        = uo_q;
      stat_vec[S_EXT]       = 1'b0;
      rd_data               = '0;
      if (acc_en && acc_op == OP_STAT) rd_data = {ival_q, stat_vec};
      else if (acc_en && acc_op == OP_CRD) rd_data = {{CNT_W{1'b0}}, cnt_q};
   end

   assign irq       = irq_q;
   assign irq_level = lvl_q;
endmodule

// File: rtl/ivl_clock_chk.sv
module ivl_clock_chk
   import ivl_clock_pkg::*;
#(
   parameter int CNT_W = 18
) (
   input logic             clk,
   input logic             rst,
   input logic             acc_en,
   input logic [1:0]       acc_op,
   input logic [2:0]       wd_lo,
   input logic             tick,
   input logic             user_mode,
   input logic             irq,
   input logic [LVL_W-1:0] irq_level,
   input logic [CNT_W-1:0] cnt,
   input logic             en,
   input logic             uo,
   input logic             flg,
   input logic             ovf
);
   logic wr, ctl;
   assign ctl = acc_en && (acc_op == OP_CTRL);
   assign wr  = ctl || (acc_en && (acc_op == OP_IWR));

   AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (cnt == '0 && !irq && !en)); // R1
   AST_TICK_STEP: assert property (@(posedge clk) disable iff (rst)
      (tick && en && !uo && !wr) |=> cnt == $past(cnt) + {{(CNT_W-1){1'b0}}, 1'b1}); // R2
   AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
      (!en && !wr) |=> $stable(cnt)); // R2
   AST_WRAP_OVF: assert property (@(posedge clk) disable iff (rst)
      (tick && en && !uo && !wr && cnt == '1) |=> (cnt == '0 && ovf)); // R3
   AST_LEVEL_LOAD: assert property (@(posedge clk) disable iff (rst)
      ctl |=> irq_level == $past(wd_lo)); // R5
   AST_CTRL_IRQ: assert property (@(posedge clk) disable iff (rst)
      ctl |=> irq == (en && (flg || ovf))); // R9
   AST_USER_GATE: assert property (@(posedge clk) disable iff (rst)
      (tick && en && uo && !user_mode && !wr) |=> $stable(cnt)); // R11
   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!acc_en && !tick) |=> $stable(irq)); // R14
endmodule

bind ivl_clock ivl_clock_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .acc_en   (acc_en),
   .acc_op   (acc_op),
   .wd_lo    (wr_data[2:0]),
   .tick     (tick),
   .user_mode(user_mode),
   .irq      (irq),
   .irq_level(irq_level),
   .cnt      (cnt_q),
   .en       (en_q),
   .uo       (uo_q),
   .flg      (flg_q),
   .ovf      (ovf_q)
);

// File: tb/ivl_clock_test.sv
module ivl_clock_test;
   localparam int CW = 10;
   localparam int DW = 2 * CW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          acc_en = 1'b0;
   logic [1:0]    acc_op = 2'd0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic          tick = 1'b0;
   logic          user_mode = 1'b0;
   logic          irq;
   logic [2:0]    irq_level;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   localparam logic [DW-1:0] K_FOFF = 20'o10,   K_OOFF = 20'o20,   K_RUN = 20'o40,
                             K_STOP = 20'o100,  K_UON  = 20'o200,  K_UOFF = 20'o400,
                             K_WIPE = 20'o1000, K_STEP = 20'o2000, K_FON  = 20'o4000,
                             K_OON  = 20'o10000;

   always #10 clk = ~clk;

   ivl_clock #(.CNT_W(CW), .USER_GATE_EN(1'b1)) uut (
      .clk(clk), .rst(rst), .acc_en(acc_en), .acc_op(acc_op), .wr_data(wr_data),
      .rd_data(rd_data), .tick(tick), .user_mode(user_mode), .irq(irq), .irq_level(irq_level)
   );

   function automatic logic [DW-1:0] sw(int lvl, int flg, int ovf, int en, int uo, int iv);
      return DW'(iv) << CW | DW'(uo) << 7 | DW'(en) << 5 | DW'(ovf) << 4 | DW'(flg) << 3 | DW'(lvl);
   endfunction

   task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] op, logic [DW-1:0] d);
      @(negedge clk);
      acc_en = 1'b1; acc_op = op; wr_data = d;
      @(negedge clk);
      acc_en = 1'b0;
   endtask

   task automatic rd(logic [1:0] op, output logic [DW-1:0] v);
      @(negedge clk);
      acc_en = 1'b1; acc_op = op;
      #2 v = rd_data;
      @(posedge clk);
      #1 acc_en = 1'b0;
   endtask

   task automatic tk(int n, logic um);
      @(negedge clk);
      tick = 1'b1; user_mode = um;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
      end
   end

   initial begin
      logic [DW-1:0] v;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1 reset state
      rd(2'd1, v); chk("R1 status", v, '0);
      rd(2'd3, v); chk("R1 counter", v, '0);
      chk("R1 irq", DW'(irq), '0);
      // R2 disabled ticks ignored
      tk(5, 1'b0);
      rd(2'd3, v); chk("R2 disabled hold", v, '0);
      // R10 interval write while disabled: no flag, no irq
      wr(2'd2, 20'd700);
      chk("R10 no irq when off", DW'(irq), '0);
      // R5 R9 enable with level 5
      wr(2'd0, K_RUN | 20'd5);
      chk("R9 no flags no irq", DW'(irq), '0);
      chk("R5 level", DW'(irq_level), 20'd5);
      rd(2'd1, v); chk("R12 status word", v, sw(5, 0, 0, 1, 0, 700));
      // R2 sweep of enabled counting
      for (int k = 1; k <= 6; k++) begin
         tk(100, 1'b0);
         rd(2'd3, v); chk("R2 count sweep", v, DW'(k * 100));
      end
      chk("R4 no flag before match", DW'(irq), '0);
      tk(100, 1'b0);
      rd(2'd1, v); chk("R4 compare flag", v, sw(5, 1, 0, 1, 0, 700));
      chk("R14 tick irq", DW'(irq), 20'd1);
      // R3 wrap
      tk(323, 1'b0);
      rd(2'd3, v); chk("R2 top value", v, 20'd1023);
      tk(1, 1'b0);
      rd(2'd3, v); chk("R3 wrap to zero", v, '0);
      rd(2'd1, v); chk("R3 overflow flag", v, sw(5, 1, 1, 1, 0, 700));
      chk("R14 irq held", DW'(irq), 20'd1);
      // R6 R9 clear both flags
      wr(2'd0, K_FOFF | K_OOFF | 20'd5);
      chk("R9 irq dropped", DW'(irq), '0);
      rd(2'd1, v); chk("R6 flags cleared", v, sw(5, 0, 0, 1, 0, 700));
      // R6 clear wins
      wr(2'd0, K_FON | K_FOFF | K_RUN | K_STOP | 20'd2);
      rd(2'd1, v); chk("R6 clear wins", v, sw(2, 0, 0, 0, 0, 700));
      // R8 step
      wr(2'd0, K_STEP | 20'd2);
      rd(2'd3, v); chk("R8 step when off", v, 20'd1);
      wr(2'd0, K_STEP | K_RUN | 20'd2);
      rd(2'd3, v); chk("R8 step before enable", v, 20'd2);
      wr(2'd0, K_STEP | 20'd2);
      rd(2'd3, v); chk("R8 step ignored when on", v, 20'd2);
      // R10 interval write while enabled
      wr(2'd2, 20'd2);
      chk("R10 irq raised", DW'(irq), 20'd1);
      rd(2'd1, v); chk("R10 match flag", v, sw(2, 1, 0, 1, 0, 2));
      wr(2'd0, K_FOFF | K_RUN | 20'd2);
      chk("R9 irq after clear", DW'(irq), '0);
      wr(2'd2, 20'd5);
      chk("R10 irq without match", DW'(irq), 20'd1);
      rd(2'd1, v); chk("R10 no flag without match", v, sw(2, 0, 0, 1, 0, 5));
      // R7 general clear
      wr(2'd0, K_OON | K_RUN | 20'd3);
      chk("R9 overflow irq", DW'(irq), 20'd1);
      wr(2'd0, K_WIPE | K_RUN | 20'd3);
      rd(2'd1, v); chk("R7 wipe status", v, sw(3, 0, 0, 1, 0, 5));
      rd(2'd3, v); chk("R7 wipe counter", v, '0);
      chk("R9 irq after wipe", DW'(irq), '0);
      wr(2'd0, K_WIPE | K_FON | K_RUN | 20'd3);
      rd(2'd1, v); chk("R7 set after wipe", v, sw(3, 1, 0, 1, 0, 5));
      chk("R9 irq set flag", DW'(irq), 20'd1);
      // R11 user-only gating
      wr(2'd0, K_WIPE | K_UON | K_RUN);
      rd(2'd1, v); chk("R6 user mode bit", v, sw(0, 0, 0, 1, 1, 5));
      tk(10, 1'b0);
      rd(2'd3, v); chk("R11 gated off", v, '0);
      tk(10, 1'b1);
      rd(2'd3, v); chk("R11 counts in user", v, 20'd10);
      chk("R14 irq on match", DW'(irq), 20'd1);
      wr(2'd0, K_UOFF | K_FOFF | K_RUN);
      tk(3, 1'b0);
      rd(2'd3, v); chk("R11 ungated", v, 20'd13);
      // R13 write beats tick
      @(negedge clk);
      tick = 1'b1; acc_en = 1'b1; acc_op = 2'd0; wr_data = K_RUN;
      @(negedge clk);
      tick = 1'b0; acc_en = 1'b0;
      rd(2'd3, v); chk("R13 tick dropped", v, 20'd13);
      // R5 level sweep
      for (int l = 0; l < 8; l++) begin
         wr(2'd0, K_STOP | DW'(l));
         chk("R5 level sweep", DW'(irq_level), DW'(l));
      end
      // R12 idle read data
      chk("R12 idle rd_data", rd_data, '0);
      done = 1'b1;
      summary();
   end
endmodule